// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator with Bit-20 Gate

This block turns a segment/offset pair into a physical byte address the way real-mode segmented addressing does. A small bank of segment registers holds the code, data, stack and extra bases. When the build option is on, it also holds two further bases. A request names one of these registers by index and supplies a 16-bit offset. The block multiplies the chosen segment by 16 and adds the offset. The sum is 21 bits wide, because a segment of 0xFFFF with an offset of 0xFFFF reaches 0x10FFEF, just under 64 KiB past the 1 MiB line.

How bit 20 of that sum is treated is fixed at build time. In the narrow (20-line) build the bit is always dropped, so addresses above 1 MiB fold back onto the bottom of memory. In the wide build the bit reaches the bus only while a one-bit gate is open. The gate is written through its own port and resets to closed, so legacy code sees the fold until software opens the gate.

Requests enter on a valid/ready channel. Results leave on a second valid/ready channel as a 24-bit bus address. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. While `addr_valid` is high and `addr_ready` is low, the address holds steady and no new request is taken.

Top module: `seg_addr_gen`

## Requirements
- R1: Bits 19:0 of the output address equal bits 19:0 of (segment × 16 + offset) for the segment register picked when the request was accepted.
- R2: The request index picks the register: 0 code, 1 data, 2 stack, 3 extra, and in the six-register build 4 and 5 for the two further bases. An index with no register behind it reads as segment zero.
- R3: In the narrow build, output bit 20 is always zero whatever the gate holds, so 0xFFFF:0xFFFF yields 0x00FFEF.
- R4: In the wide build with the gate open, output bit 20 carries bit 20 of the sum, so 0xFFFF:0xFFFF yields 0x10FFEF.
- R5: The gate resets to closed. While it is closed, the wide build forces output bit 20 to zero.
- R6: Output bits 23:21 are always zero.
- R7: `addr_valid` rises on the clock edge that accepts a request. `req_ready` equals `!addr_valid || addr_ready`. While `addr_valid` is high and `addr_ready` is low, `addr_valid` and `addr_out` hold steady.
- R8: When a segment write and a request that reads the same register share a clock edge, the request uses the old value. The new value applies from the next request onward.
- R9: A segment write whose index has no register behind it changes no register.
- R10: A gate write on the same edge as an accepted request does not affect that request. It applies from the next request onward.
- R11: After reset, `addr_valid` is low, `req_ready` is high and every segment register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_idx | input | IDX_W (2 or 3) | Segment register write index |
| seg_wr_data | input | 16 | Segment value to write |
| gate_wr_en | input | 1 | Bit-20 gate write strobe |
| gate_wr_val | input | 1 | New gate value, 1 = open |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_seg | input | IDX_W (2 or 3) | Segment register index for the request |
| req_off | input | 16 | Offset for the request |
| addr_valid | output | 1 | Address present |
| addr_ready | input | 1 | Consumer takes the address |
| addr_out | output | 24 | Physical bus address |

## Verification
The hardest case to reach from the ports is a request and an update landing on the same edge. This covers a segment write to the selected register and a gate flip, where the old value must win. The bench drives both strobes together with `req_valid` in one cycle, checks that result, and then issues a follow-up request to show the new value has taken hold. A second hard case is back-pressure that collides with a waiting request. The bench holds `addr_ready` low with a second request pending, then releases it so that draining the old address and accepting the new request happen on one edge.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  // Segment register indices; the order is decoded by the requester.
  typedef enum logic [2:0] {
    SEL_CODE  = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_STACK = 3'd2,
    SEL_EXTRA = 3'd3,
    SEL_AUX0  = 3'd4,
    SEL_AUX1  = 3'd5
  } seg_sel_e;

  localparam int unsigned BASE_SEGS  = 4;
  localparam int unsigned EXTRA_CNT  = 2;
  localparam int unsigned PARA_SHIFT = 4;

  function automatic int unsigned seg_count(input bit extra);
    return extra ? BASE_SEGS + EXTRA_CNT : BASE_SEGS;
  endfunction
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int unsigned NUM_SEGS = 4,
  parameter int unsigned SEG_W    = 16,
  parameter int unsigned IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEG_W-1:0] rd_data
);
  logic [NUM_SEGS-1:0][SEG_W-1:0] regs_q;
  logic wr_hit;

  assign wr_hit = wr_en && (32'(wr_idx) < NUM_SEGS);

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (wr_hit && (32'(wr_idx) == g))
        regs_q[g] <= wr_data;
    end
  end

  // Read port sees flop contents: a same-cycle write is not bypassed.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SEGS; i++)
      if (32'(rd_idx) == i) rd_data = regs_q[i];
  end

  // R9: out-of-range write leaves the bank untouched
  a_r9_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_idx) >= NUM_SEGS)) |=> $stable(regs_q));

  // R8: an in-range write lands on the next edge
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (regs_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/seg_sum.sv
module seg_sum #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SUM_W = 21
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [SUM_W-1:0] sum
);
  import segaddr_pkg::*;
  logic [SUM_W-1:0] seg_ext;
  logic [SUM_W-1:0] off_ext;

  always_comb begin
    seg_ext = SUM_W'({seg, {PARA_SHIFT{1'b0}}});
    off_ext = SUM_W'(off);
    sum     = seg_ext + off_ext;
  end
endmodule

// File: rtl/a20_gate.sv
module a20_gate #(
  parameter bit          WIDE_BUS = 1'b1,
  parameter int unsigned SUM_W    = 21,
  parameter int unsigned OUT_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_wr_en,
  input  logic             gate_wr_val,
  input  logic [SUM_W-1:0] sum,
  output logic [OUT_W-1:0] bus_addr
);
  localparam int unsigned LINE = SUM_W - 1;
  logic gate_q;
  logic line_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)          gate_q <= 1'b0;
    else if (gate_wr_en) gate_q <= gate_wr_val;
  end

  always_comb begin
    line_bit = WIDE_BUS ? (sum[LINE] & gate_q) : 1'b0;
    bus_addr = {{(OUT_W-SUM_W){1'b0}}, line_bit, sum[LINE-1:0]};
  end

  // R5: gate closed out of reset
  a_r5_gate_closed_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !gate_q);
endmodule

// File: rtl/addr_stage.sv
module addr_stage #(
  parameter int unsigned OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OUT_W-1:0] in_addr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_addr
);
  logic             vld_q;
  logic [OUT_W-1:0] addr_q;
  logic             take;

  assign in_ready  = !vld_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = vld_q;
  assign out_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      addr_q <= in_addr;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  // R7: held output is stable under back-pressure
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));
  // R7: accepted request shows up next cycle
  a_r7_valid_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter bit          EXTRA_SEGS = 1'b1,
  parameter bit          WIDE_BUS   = 1'b1,
  parameter int unsigned SEG_W      = 16,
  parameter int unsigned OFF_W      = 16,
  parameter int unsigned OUT_W      = 24,
  localparam int unsigned NUM_SEGS  = segaddr_pkg::seg_count(EXTRA_SEGS),
  localparam int unsigned IDX_W     = $clog2(NUM_SEGS),
  localparam int unsigned SUM_W     = SEG_W + segaddr_pkg::PARA_SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [IDX_W-1:0] seg_wr_idx,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic             gate_wr_en,
  input  logic             gate_wr_val,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  output logic             addr_valid,
  input  logic             addr_ready,
  output logic [OUT_W-1:0] addr_out
);
  logic [SEG_W-1:0] seg_val;
  logic [SUM_W-1:0] sum;
  logic [OUT_W-1:0] bus_addr;

  seg_bank #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seg_wr_en), .wr_idx(seg_wr_idx), .wr_data(seg_wr_data),
    .rd_idx(req_seg), .rd_data(seg_val));

  seg_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SUM_W(SUM_W)) u_sum (
    .seg(seg_val), .off(req_off), .sum(sum));

  a20_gate #(.WIDE_BUS(WIDE_BUS), .SUM_W(SUM_W), .OUT_W(OUT_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .gate_wr_en(gate_wr_en), .gate_wr_val(gate_wr_val),
    .sum(sum), .bus_addr(bus_addr));

  addr_stage #(.OUT_W(OUT_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_addr(bus_addr),
    .out_valid(addr_valid), .out_ready(addr_ready), .out_addr(addr_out));

  // R6: bus bits above the gated line never set
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (addr_out[OUT_W-1:SUM_W] == '0));

  // R1: low twenty bits follow the sum seen at acceptance
  a_r1_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (addr_out[SUM_W-2:0] == $past(sum[SUM_W-2:0])));

  if (!WIDE_BUS) begin : g_narrow
    // R3: narrow build never drives the line bit
    a_r3_no_line_bit: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> !addr_out[SUM_W-1]);
  end
endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // wide, six-register instance
  logic        seg_wr_en = 0, gate_wr_en = 0, gate_wr_val = 0;
  logic [2:0]  seg_wr_idx = '0, req_seg = '0;
  logic [15:0] seg_wr_data = '0, req_off = '0;
  logic        req_valid = 0, addr_ready = 1;
  logic        req_ready, addr_valid;
  logic [23:0] addr_out;

  // narrow, four-register instance
  logic        l_seg_wr_en = 0, l_gate_wr_en = 0, l_gate_wr_val = 0;
  logic [1:0]  l_seg_wr_idx = '0, l_req_seg = '0;
  logic [15:0] l_seg_wr_data = '0, l_req_off = '0;
  logic        l_req_valid = 0;
  logic        l_req_ready, l_addr_valid;
  logic [23:0] l_addr_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  seg_addr_gen #(.EXTRA_SEGS(1'b1), .WIDE_BUS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_data(seg_wr_data),
    .gate_wr_en(gate_wr_en), .gate_wr_val(gate_wr_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out));

  seg_addr_gen #(.EXTRA_SEGS(1'b0), .WIDE_BUS(1'b0)) dut_l (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(l_seg_wr_en), .seg_wr_idx(l_seg_wr_idx), .seg_wr_data(l_seg_wr_data),
    .gate_wr_en(l_gate_wr_en), .gate_wr_val(l_gate_wr_val),
    .req_valid(l_req_valid), .req_ready(l_req_ready), .req_seg(l_req_seg), .req_off(l_req_off),
    .addr_valid(l_addr_valid), .addr_ready(1'b1), .addr_out(l_addr_out));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wseg(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk); seg_wr_en = 1; seg_wr_idx = idx; seg_wr_data = d;
    @(negedge clk); seg_wr_en = 0;
  endtask

  task automatic wgate(input logic v);
    @(negedge clk); gate_wr_en = 1; gate_wr_val = v;
    @(negedge clk); gate_wr_en = 0;
  endtask

  task automatic xreq(input logic [2:0] idx, input logic [15:0] off,
                      input logic [23:0] exp, input string tag);
    @(negedge clk); req_valid = 1; req_seg = idx; req_off = off;
    @(negedge clk); req_valid = 0;
    check({tag, " valid"}, 32'(addr_valid), 32'd1);
    check(tag, 32'(addr_out), 32'(exp));
  endtask

  task automatic t_reset;
    check("R11 addr_valid after reset", 32'(addr_valid), 0);
    check("R11 req_ready after reset", 32'(req_ready), 1);
    xreq(3'd0, 16'h0123, 24'h000123, "R11 code segment zero after reset");
  endtask

  task automatic t_gate_default;
    wseg(3'd0, 16'hFFFF);
    xreq(3'd0, 16'hFFFF, 24'h00FFEF, "R5 closed gate masks bit 20");
    wgate(1'b1);
    xreq(3'd0, 16'hFFFF, 24'h10FFEF, "R4 open gate passes top sum");
  endtask

  task automatic t_select;
    wseg(3'd1, 16'h1234); wseg(3'd2, 16'hA000); wseg(3'd3, 16'h0001);
    wseg(3'd4, 16'hF000); wseg(3'd5, 16'hFFFF);
    xreq(3'd1, 16'h0010, 24'h012350, "R2 R1 data segment");
    xreq(3'd2, 16'h5678, 24'h0A5678, "R2 R1 stack segment");
    xreq(3'd3, 16'h0000, 24'h000010, "R2 extra segment");
    xreq(3'd4, 16'hFFFF, 24'h0FFFFF, "R2 R6 aux0 segment");
    xreq(3'd5, 16'h0010, 24'h100000, "R2 R4 aux1 segment crosses 1 MiB");
    xreq(3'd7, 16'h0042, 24'h000042, "R2 unbacked index reads zero");
  endtask

  task automatic t_bad_write;
    wseg(3'd6, 16'hBEEF);
    wseg(3'd7, 16'hBEEF);
    xreq(3'd6, 16'h0000, 24'h000000, "R9 write to index 6 ignored");
    xreq(3'd0, 16'h0000, 24'h0FFFF0, "R9 code unchanged");
    xreq(3'd5, 16'h0000, 24'h0FFFF0, "R9 aux1 unchanged");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    seg_wr_en = 1; seg_wr_idx = 3'd1; seg_wr_data = 16'h2000;
    req_valid = 1; req_seg = 3'd1; req_off = 16'h0000;
    @(negedge clk); seg_wr_en = 0; req_valid = 0;
    check("R8 same-cycle write uses old value", 32'(addr_out), 32'h012340);
    xreq(3'd1, 16'h0000, 24'h020000, "R8 write applies next request");
    @(negedge clk);
    gate_wr_en = 1; gate_wr_val = 0;
    req_valid = 1; req_seg = 3'd5; req_off = 16'h0010;
    @(negedge clk); gate_wr_en = 0; req_valid = 0;
    check("R10 same-cycle gate close uses old gate", 32'(addr_out), 32'h100000);
    xreq(3'd5, 16'h0010, 24'h000000, "R10 closed gate wraps next request");
  endtask

  task automatic t_backpressure;
    @(negedge clk); addr_ready = 0; req_valid = 1; req_seg = 3'd2; req_off = 16'h0001;
    @(negedge clk);
    check("R7 valid after accept", 32'(addr_valid), 1);
    check("R7 ready low when full and stalled", 32'(req_ready), 0);
    req_off = 16'h0002;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 held address stable", 32'(addr_out), 32'h0A0001);
    end
    check("R7 still valid under stall", 32'(addr_valid), 1);
    check("R7 ready follows addr_ready", 32'(req_ready), 0);
    addr_ready = 1;
    #0;
    check("R7 ready high when drained", 32'(req_ready), 1);
    @(negedge clk); req_valid = 0;
    check("R7 drain and accept same edge", 32'(addr_out), 32'h0A0002);
    check("R7 valid kept across drain+accept", 32'(addr_valid), 1);
    @(negedge clk);
    check("R7 valid drops once consumed", 32'(addr_valid), 0);
  endtask

  task automatic t_narrow;
    @(negedge clk); l_gate_wr_en = 1; l_gate_wr_val = 1;
    l_seg_wr_en = 1; l_seg_wr_idx = 2'd0; l_seg_wr_data = 16'hFFFF;
    @(negedge clk); l_gate_wr_en = 0; l_seg_wr_en = 0;
    l_req_valid = 1; l_req_seg = 2'd0; l_req_off = 16'hFFFF;
    @(negedge clk); l_req_valid = 0;
    check("R3 narrow build wraps despite open gate", 32'(l_addr_out), 32'h00FFEF);
    @(negedge clk); l_seg_wr_en = 1; l_seg_wr_idx = 2'd3; l_seg_wr_data = 16'hFFF0;
    @(negedge clk); l_seg_wr_en = 0;
    l_req_valid = 1; l_req_seg = 2'd3; l_req_off = 16'h0105;
    @(negedge clk); l_req_valid = 0;
    check("R3 R2 narrow extra segment", 32'(l_addr_out), 32'h000005);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_gate_default;
    t_select;
    t_bad_write;
    t_same_cycle;
    t_backpressure;
    t_narrow;
    done = 1;
    summary;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      summary;
      $finish;
    end
  end
endmodule